// File: doc/BRIEF.md
# Gate-Qualified Event Counter

This block is a 16-bit up-counter that runs on the count clock and advances only while a processed gate signal is open. The gate can come from one of four places: an external gate pin, the wrap pulse of an 8-bit auxiliary timer, or one of two comparator outputs. Each comparator can be taken directly or through a clock synchroniser. The selected source can be inverted, and the result then passes through two optional stages.

The first stage is a toggle stage. It turns each full period of the source into one open interval. The second stage is a single-pulse stage, which software arms with a go strobe. It opens the gate on the next rising edge and disarms itself on the following falling edge. When both stages are on, the counter measures exactly one source period in count clocks.

The processed gate level is always visible as a status output, even when gating is off. A falling edge of that level sets a sticky event flag. The flag drives an interrupt output through an enable, and software clears it with a strobe. Software can also load the counter directly.

Top module: `gate_ctl_counter`

## Requirements
- R1: `src_sel_i` picks the gate source: 2'b00 gate pin, 2'b01 auxiliary overflow pulse, 2'b10 comparator 1, 2'b11 comparator 2. With toggle and single-pulse off, `gate_val_o` equals the selected, polarity-adjusted source delayed by one clock.
- R2: A one-clock high pulse on `aux_ovf_i` with source 2'b01 selected opens the gate for exactly one clock, so the counter advances by one per pulse.
- R3: With `cmp_sync_i[k]`=1, comparator k reaches `gate_val_o` three clocks after it changes (two synchroniser stages plus one). With `cmp_sync_i[k]`=0 it takes one clock.
- R4: `gate_inv_i`=1 inverts the selected source before the toggle and single-pulse stages, so the counter runs while the source is low.
- R5: With `tog_en_i`=1, the gate flips on every rising edge of the polarity-adjusted source (visible one clock later). With `tog_en_i`=0, the toggle state is cleared and held clear, so the first rising edge after re-enabling opens the gate.
- R6: With `sp_en_i`=1, a `go_set_i` strobe sets `go_o` on the next clock. The gate stays closed until the next rising edge of the gate. It then stays open until that gate falls, and `go_o` clears on that fall. Nothing more is counted until `go_o` is set again. `go_set_i` is ignored while `sp_en_i`=0, and clearing `sp_en_i` forces `go_o` low on the next clock.
- R7: With toggle and single-pulse both enabled, one armed measurement counts exactly one full source period, in count clocks.
- R8: On each clock, `count_o` loads `cnt_wdata_i` when `cnt_wr_i`=1; this has priority. Otherwise it adds one when `cnt_on_i`=1 and either `gate_en_i`=0 or `gate_val_o`=1. It wraps from 16'hFFFF to 0 and holds when `cnt_on_i`=0.
- R9: `gate_val_o` tracks the processed gate even when `gate_en_i`=0.
- R10: A high-to-low transition of `gate_val_o` sets `irq_flag_o` one clock later, whether or not gating is enabled. The flag stays set until `irq_clr_i`, and a set in the same clock wins over the clear. `irq_o` = `irq_flag_o` AND `irq_en_i`.
- R11: After reset, `count_o`=0 and `gate_val_o`, `go_o`, `irq_flag_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_on_i | input | 1 | Counter run enable |
| gate_en_i | input | 1 | 1: count only while gate open; 0: count every clock |
| src_sel_i | input | 2 | Gate source select (see R1) |
| gate_inv_i | input | 1 | Invert selected source |
| tog_en_i | input | 1 | Toggle stage enable |
| sp_en_i | input | 1 | Single-pulse stage enable |
| go_set_i | input | 1 | Arm strobe for single-pulse stage |
| cmp_sync_i | input | 2 | Per-comparator synchroniser select (bit 0 = comparator 1) |
| gate_pin_i | input | 1 | External gate pin |
| aux_ovf_i | input | 1 | Auxiliary 8-bit timer wrap pulse |
| cmp1_i | input | 1 | Comparator 1 output |
| cmp2_i | input | 1 | Comparator 2 output |
| cnt_wr_i | input | 1 | Counter load strobe |
| cnt_wdata_i | input | 16 | Counter load value |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Event flag clear strobe |
| count_o | output | 16 | Counter value |
| go_o | output | 1 | Single-pulse armed/running status |
| gate_val_o | output | 1 | Processed gate level |
| irq_flag_o | output | 1 | Sticky gate event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Corrupt state in the gate stages surfaces at `gate_val_o` within one clock. A toggle state that was not cleared opens on the wrong edge, and a single-pulse stage that fails to disarm leaves `go_o` high after the fall. These faults reach `count_o` on the next clock as a wrong measured length. An error in the event flag path shows on `irq_flag_o` exactly one clock after the gate falls. A bench model that steps alongside the design compares all five outputs on every clock, so a fault is reported in the cycle it first becomes visible. Directed runs pin down the exact counted widths, periods and latencies.

// File: rtl/gcu_pkg.sv
package gcu_pkg;
  localparam int unsigned N_CMP = 2;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_AUX  = 2'b01,
    SRC_CMP1 = 2'b10,
    SRC_CMP2 = 2'b11
  } gate_src_e;
endpackage

// File: rtl/gcu_src_mux.sv
module gcu_src_mux
  import gcu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gate_src_e        src_sel_i,
  input  logic             gate_inv_i,
  input  logic             gate_pin_i,
  input  logic             aux_ovf_i,
  input  logic [N_CMP-1:0] cmp_i,
  input  logic [N_CMP-1:0] cmp_sync_i,
  output logic             gate_o
);
  logic [N_CMP-1:0] cmp_eff;
  logic             raw;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    logic [SYNC_STAGES-1:0] sh_q;
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= cmp_i[k];
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[SYNC_STAGES-2:0], cmp_i[k]};
      end
    end
    assign cmp_eff[k] = cmp_sync_i[k] ? sh_q[SYNC_STAGES-1] : cmp_i[k];
  end

  always_comb begin
    unique case (src_sel_i)
      SRC_PIN:  raw = gate_pin_i;
      SRC_AUX:  raw = aux_ovf_i;
      SRC_CMP1: raw = cmp_eff[0];
      SRC_CMP2: raw = cmp_eff[1];
      default:  raw = gate_pin_i;
    endcase
  end

  // polarity applied ahead of toggle / single-pulse stages
  assign gate_o = raw ^ gate_inv_i;
endmodule

// File: rtl/gcu_gate_path.sv
module gcu_gate_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic tog_en_i,
  input  logic sp_en_i,
  input  logic go_set_i,
  output logic gate_val_o,
  output logic go_o
);
  logic gp_q, tog_q, gt_q, go_q, run_q;
  logic gp_rise, gt, gt_rise, gt_fall;

  assign gp_rise = gate_i & ~gp_q;
  assign gt      = tog_en_i ? tog_q : gp_q;
  assign gt_rise = gt & ~gt_q;
  assign gt_fall = ~gt & gt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_q  <= 1'b0;
      tog_q <= 1'b0;
      gt_q  <= 1'b0;
    end else begin
      gp_q <= gate_i;
      gt_q <= gt;
      if (!tog_en_i)    tog_q <= 1'b0;
      else if (gp_rise) tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (!sp_en_i) begin
      go_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (go_q) begin
      if (run_q) begin
        if (gt_fall) begin
          go_q  <= 1'b0;
          run_q <= 1'b0;
        end
      end else if (gt_rise) begin
        run_q <= 1'b1;
      end
    end else if (go_set_i) begin
      go_q <= 1'b1;
    end
  end

  // window opens combinationally on the arming edge so its first clock counts
  assign gate_val_o = sp_en_i ? (gt & go_q & (run_q | gt_rise)) : gt;
  assign go_o       = go_q;

  AST_GO_DROPS_WITHOUT_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_en_i |=> !go_o); // R6
  AST_RUN_NEEDS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> go_q); // R6
  AST_SP_CLOSED_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_en_i && !go_q) |-> !gate_val_o); // R6
  AST_TOG_HELD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tog_en_i |=> !tog_q); // R5
endmodule

// File: rtl/gcu_count_irq.sv
module gcu_count_irq #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_on_i,
  input  logic             gate_en_i,
  input  logic             gate_val_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             gval_q, flag_q, inc;

  assign inc = cnt_on_i & (~gate_en_i | gate_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  count_q <= '0;
    else if (wr_i) count_q <= wdata_i;
    else if (inc)  count_q <= count_q + 1'b1;
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gval_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      gval_q <= gate_val_i;
      if (gval_q && !gate_val_i) flag_q <= 1'b1;
      else if (irq_clr_i)        flag_q <= 1'b0;
    end
  end

  assign count_o    = count_q;
  assign irq_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !cnt_on_i) |=> $stable(count_o)); // R8
  AST_HOLD_WHEN_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && gate_en_i && !gate_val_i) |=> $stable(count_o)); // R8
  AST_FLAG_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_val_i) |=> irq_flag_o); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o); // R10
endmodule

// File: rtl/gate_ctl_counter.sv
module gate_ctl_counter
  import gcu_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_on_i,
  input  logic             gate_en_i,
  input  logic [1:0]       src_sel_i,
  input  logic             gate_inv_i,
  input  logic             tog_en_i,
  input  logic             sp_en_i,
  input  logic             go_set_i,
  input  logic [1:0]       cmp_sync_i,
  input  logic             gate_pin_i,
  input  logic             aux_ovf_i,
  input  logic             cmp1_i,
  input  logic             cmp2_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             go_o,
  output logic             gate_val_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  logic gate_src;

  gcu_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_sel_i  (gate_src_e'(src_sel_i)),
    .gate_inv_i (gate_inv_i),
    .gate_pin_i (gate_pin_i),
    .aux_ovf_i  (aux_ovf_i),
    .cmp_i      ({cmp2_i, cmp1_i}),
    .cmp_sync_i (cmp_sync_i),
    .gate_o     (gate_src)
  );

  gcu_gate_path u_path (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (gate_src),
    .tog_en_i   (tog_en_i),
    .sp_en_i    (sp_en_i),
    .go_set_i   (go_set_i),
    .gate_val_o (gate_val_o),
    .go_o       (go_o)
  );

  gcu_count_irq #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_on_i   (cnt_on_i),
    .gate_en_i  (gate_en_i),
    .gate_val_i (gate_val_o),
    .wr_i       (cnt_wr_i),
    .wdata_i    (cnt_wdata_i),
    .irq_en_i   (irq_en_i),
    .irq_clr_i  (irq_clr_i),
    .count_o    (count_o),
    .irq_flag_o (irq_flag_o),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/gate_ctl_counter_test.sv
module gate_ctl_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cnt_on, gate_en, gate_inv, tog_en, sp_en, go_set;
  logic [1:0]  src_sel, cmp_sync;
  logic        gate_pin, aux_ovf, cmp1, cmp2, cnt_wr, irq_en, irq_clr;
  logic [15:0] cnt_wdata, count;
  logic        go, gate_val, irq_flag, irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_ctl_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_on_i(cnt_on), .gate_en_i(gate_en),
    .src_sel_i(src_sel), .gate_inv_i(gate_inv), .tog_en_i(tog_en), .sp_en_i(sp_en),
    .go_set_i(go_set), .cmp_sync_i(cmp_sync), .gate_pin_i(gate_pin), .aux_ovf_i(aux_ovf),
    .cmp1_i(cmp1), .cmp2_i(cmp2), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .count_o(count), .go_o(go),
    .gate_val_o(gate_val), .irq_flag_o(irq_flag), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model built from the requirement text
  logic [1:0]  m_s0, m_s1;
  logic        m_gpq, m_tog, m_gtq, m_go, m_run, m_gvq, m_flag;
  logic [15:0] m_cnt;

  function automatic logic m_gp();
    logic s;
    case (src_sel)
      2'b00:   s = gate_pin;
      2'b01:   s = aux_ovf;
      2'b10:   s = cmp_sync[0] ? m_s1[0] : cmp1;
      default: s = cmp_sync[1] ? m_s1[1] : cmp2;
    endcase
    return s ^ gate_inv;
  endfunction

  function automatic logic m_gt();
    return tog_en ? m_tog : m_gpq;
  endfunction

  function automatic logic m_gv();
    logic g;
    g = m_gt();
    if (!sp_en) return g;
    return g & m_go & (m_run | ~m_gtq);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic gp, gt, gv;
    if (!rst_n) begin
      m_s0 <= '0; m_s1 <= '0; m_gpq <= 0; m_tog <= 0; m_gtq <= 0;
      m_go <= 0; m_run <= 0; m_gvq <= 0; m_flag <= 0; m_cnt <= '0;
    end else begin
      gp = m_gp(); gt = m_gt(); gv = m_gv();
      m_s0 <= {cmp2, cmp1};
      m_s1 <= m_s0;
      m_gpq <= gp;
      m_gtq <= gt;
      if (!tog_en) m_tog <= 0;
      else if (gp && !m_gpq) m_tog <= ~m_tog;
      if (!sp_en) begin m_go <= 0; m_run <= 0; end
      else if (m_go) begin
        if (m_run) begin
          if (!gt && m_gtq) begin m_go <= 0; m_run <= 0; end
        end else if (gt && !m_gtq) m_run <= 1;
      end else if (go_set) m_go <= 1;
      m_gvq <= gv;
      if (m_gvq && !gv) m_flag <= 1;
      else if (irq_clr) m_flag <= 0;
      if (cnt_wr) m_cnt <= cnt_wdata;
      else if (cnt_on && (!gate_en || gv)) m_cnt <= m_cnt + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 count vs model", 32'(count), 32'(m_cnt));
      check("R1 gate value vs model", 32'(gate_val), 32'(m_gv()));
      check("R6 go vs model", 32'(go), 32'(m_go));
      check("R10 flag vs model", 32'(irq_flag), 32'(m_flag));
      check("R10 irq vs model", 32'(irq), 32'(m_flag & irq_en));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic inv, input logic tog,
                     input logic sp, input logic gen);
    src_sel = sel; gate_inv = inv; tog_en = tog; sp_en = sp; gate_en = gen;
  endtask

  task automatic load(input logic [15:0] v);
    cnt_wr = 1; cnt_wdata = v; step(1); cnt_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    cnt_on = 1; gate_en = 0; src_sel = 0; gate_inv = 0; tog_en = 0; sp_en = 0; go_set = 0;
    cmp_sync = 0; gate_pin = 0; aux_ovf = 0; cmp1 = 0; cmp2 = 0; cnt_wr = 0; cnt_wdata = 0;
    irq_en = 1; irq_clr = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset count", 32'(count), 0);
    check("R11 reset gate value", 32'(gate_val), 0);
    check("R11 reset go", 32'(go), 0);
    check("R11 reset flag", 32'(irq_flag), 0);
    check("R11 reset irq", 32'(irq), 0);
    rst_n = 1;
    irq_en = 0;
    step(2);

    // R8: write priority, wrap, hold
    cfg(2'b00, 0, 0, 0, 0);
    load(16'hFFFE);
    check("R8 load wins over increment", 32'(count), 32'hFFFE);
    step(3);
    check("R8 wrap", 32'(count), 32'h0001);
    cnt_on = 0; step(5);
    check("R8 hold when off", 32'(count), 32'h0001);
    cnt_on = 1;

    // R1: pin gate width
    cfg(2'b00, 0, 0, 0, 1); gate_pin = 0; step(2);
    load(16'h0); gate_pin = 1;
    step(1);
    check("R1 gate value follows pin", 32'(gate_val), 1);
    step(5); gate_pin = 0; step(4);
    check("R1 pin-high width counted", 32'(count), 6);

    // R4: inverted polarity
    cfg(2'b00, 1, 0, 0, 1); gate_pin = 0; step(2);
    load(16'h0); gate_pin = 1; step(4); gate_pin = 0; step(6);
    check("R4 counts while source low", 32'(count), 6);
    gate_inv = 0; step(2);

    // R2: auxiliary overflow pulses
    cfg(2'b01, 0, 0, 0, 1); irq_clr = 1; step(1); irq_clr = 0;
    load(16'h0);
    for (int i = 0; i < 3; i++) begin
      aux_ovf = 1; step(1); aux_ovf = 0; step(4);
    end
    check("R2 one count per overflow pulse", 32'(count), 3);
    check("R10 flag after gate fall", 32'(irq_flag), 1);

    // R3: comparator synchroniser latency
    cfg(2'b10, 0, 0, 0, 1); cmp_sync = 2'b01; cmp1 = 0; step(4);
    cmp1 = 1; step(2);
    check("R3 synced comparator not yet through", 32'(gate_val), 0);
    step(1);
    check("R3 synced comparator after three clocks", 32'(gate_val), 1);
    cfg(2'b11, 0, 0, 0, 1); cmp2 = 0; step(3);
    cmp2 = 1; step(1);
    check("R3 direct comparator after one clock", 32'(gate_val), 1);
    cmp1 = 0; cmp2 = 0; cmp_sync = 0; cfg(2'b00, 0, 0, 0, 1); step(4);

    // R5: toggle stage
    gate_pin = 0; tog_en = 1; step(2);
    check("R5 toggle starts closed", 32'(gate_val), 0);
    gate_pin = 1; step(1);
    check("R5 first rise opens", 32'(gate_val), 1);
    gate_pin = 0; step(2);
    check("R5 fall keeps open", 32'(gate_val), 1);
    gate_pin = 1; step(1);
    check("R5 second rise closes", 32'(gate_val), 0);
    gate_pin = 0; step(1);
    gate_pin = 1; step(1);
    gate_pin = 0; tog_en = 0; step(2);
    tog_en = 1; step(1);
    gate_pin = 1; step(1);
    check("R5 state cleared while disabled", 32'(gate_val), 1);
    gate_pin = 0; tog_en = 0; step(3);

    // R6: single pulse
    cfg(2'b00, 0, 0, 1, 1); gate_pin = 1; step(3);
    go_set = 1; step(1); go_set = 0;
    check("R6 go set by strobe", 32'(go), 1);
    step(2);
    check("R6 waits for a new rising edge", 32'(gate_val), 0);
    load(16'h0);
    gate_pin = 0; step(3);
    gate_pin = 1; step(5); gate_pin = 0; step(4);
    check("R6 one pulse counted", 32'(count), 5);
    check("R6 go cleared after trailing edge", 32'(go), 0);
    gate_pin = 1; step(5); gate_pin = 0; step(4);
    check("R6 no count after disarm", 32'(count), 5);
    sp_en = 0; go_set = 1; step(1); go_set = 0;
    check("R6 go ignored without single-pulse", 32'(go), 0);
    sp_en = 1; go_set = 1; step(1); go_set = 0;
    check("R6 re-armed", 32'(go), 1);
    sp_en = 0; step(1);
    check("R6 disable forces go low", 32'(go), 0);

    // R7: toggle plus single pulse measures one period
    cfg(2'b00, 0, 1, 1, 1); gate_pin = 0; step(3);
    go_set = 1; step(1); go_set = 0;
    load(16'h0);
    for (int i = 0; i < 3; i++) begin
      gate_pin = 1; step(3); gate_pin = 0; step(4);
    end
    step(3);
    check("R7 exactly one period counted", 32'(count), 7);
    check("R7 disarmed after period", 32'(go), 0);
    cfg(2'b00, 0, 0, 0, 0); step(2);

    // R9 / R10: status and flag with gating off
    irq_clr = 1; step(1); irq_clr = 0;
    check("R10 flag cleared by strobe", 32'(irq_flag), 0);
    gate_pin = 1; step(1);
    check("R9 status valid with gating off", 32'(gate_val), 1);
    gate_pin = 0; step(1);
    check("R9 status low after fall", 32'(gate_val), 0);
    check("R10 flag not yet set", 32'(irq_flag), 0);
    irq_clr = 1; step(1); irq_clr = 0;
    check("R10 set wins over clear", 32'(irq_flag), 1);
    irq_en = 0; #1;
    check("R10 irq masked", 32'(irq), 0);
    irq_en = 1; #1;
    check("R10 irq when enabled", 32'(irq), 1);
    step(3);
    check("R10 flag sticky", 32'(irq_flag), 1);
    irq_clr = 1; step(1); irq_clr = 0;
    check("R10 flag cleared", 32'(irq_flag), 0);
    check("R10 irq drops with flag", 32'(irq), 0);

    // random phase, checked every clock against the model
    for (int blk = 0; blk < 80; blk++) begin
      cfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      cmp_sync = 2'($urandom_range(0, 3));
      irq_en = 1'($urandom_range(0, 1));
      cnt_on = ($urandom_range(0, 7) != 0);
      for (int c = 0; c < 60; c++) begin
        if ($urandom_range(0, 5) == 0) gate_pin = ~gate_pin;
        if ($urandom_range(0, 7) == 0) cmp1 = ~cmp1;
        if ($urandom_range(0, 7) == 0) cmp2 = ~cmp2;
        aux_ovf = ($urandom_range(0, 19) == 0);
        go_set = ($urandom_range(0, 14) == 0);
        irq_clr = ($urandom_range(0, 24) == 0);
        cnt_wr = ($urandom_range(0, 59) == 0);
        cnt_wdata = 16'($urandom);
        step(1);
      end
      aux_ovf = 0; go_set = 0; irq_clr = 0; cnt_wr = 0;
    end

    step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule